// File: doc/BRIEF.md
# Pipelined Store Path for a Two-Way Data Cache

This block holds the tag, valid and data arrays of a small two-way set-associative data cache and splits every store into two pipeline stages. In the first stage a store presented by the core is compared against both tags of its set. In the second stage, one cycle later, the store's data is written, under its byte enables, into the one way that matched. The tag check of a new store therefore overlaps the array write of the store accepted just before it. The block never writes data in the cycle that the tag check happens.

Loads are looked up in a single cycle: tags and data of both ways are read together, and a mismatch simply discards what was read. A store that has passed its tag check but has not reached the array yet sits in a pending register. A load that falls on the same word takes the pending bytes in place of the stale array bytes. A store that misses holds the core through a not-ready signal. It stays in the tag stage until a line fill, driven from outside through a fill port together with the way to replace, installs the line and the tag matches.

Top module: `store_pipe_cache`

## Requirements
- R1: After reset no line is valid: every load reports a miss and a store is not accepted (`st_ready` low).
- R2: A load returns, in the same cycle, `ld_hit` high and the addressed word when either way of its set holds a valid matching tag. On a miss `ld_hit` is low and `ld_data` is zero. The word address is split as tag in bits [7:4], set in [3:2] and word in line in [1:0].
- R3: A store whose tag misses gets `st_ready` low, is not captured, and leaves all cached words unchanged, for as long as it is held.
- R4: A store that hits is accepted in the cycle it is presented and becomes visible to loads from the next cycle on. Loads in its own cycle still see the old word.
- R5: A store writes only the way that matched. The word at the same set and offset in the other way keeps its value.
- R6: Only bytes whose enable bit is set are written; `st_be[i]` covers data bits [8i+7:8i].
- R7: A load of the word held in the pending register returns the pending bytes merged over the array word, byte by byte.
- R8: Stores presented on consecutive cycles are all accepted without a stall when they hit, and stores to the same word combine in program order.
- R9: A fill installs the given line (tag and set from `fill_line` bits [5:2] and [1:0], word k from `fill_data` bits [32k+31:32k]) into the given way. A store stalled on that line is accepted in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request present |
| st_addr | input | 8 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| st_ready | output | 1 | Store tag matched; request is taken this cycle |
| ld_valid | input | 1 | Load request present |
| ld_addr | input | 8 | Load word address |
| ld_hit | output | 1 | Load tag matched |
| ld_data | output | 32 | Load result, zero on miss |
| fill_valid | input | 1 | Line fill present |
| fill_way | input | 1 | Way that receives the fill |
| fill_line | input | 6 | Tag and set of the filled line |
| fill_data | input | 128 | Filled line, word 0 in the low bits |

## Verification
A wrong tag or valid bit shows at once as a wrong `ld_hit` on the next load of that address, or as a store wrongly stalled or wrongly accepted in the same cycle. A corrupt data word or a write to the wrong way or byte only shows when that word is loaded. The sweeps therefore reload every address of the small space after each phase. A lost or stale pending register is visible within one cycle, because each store is followed at once by a load of the same word.

// File: rtl/store_pipe_cache.sv
module store_pipe_cache #(
  parameter int DW    = 32,
  parameter int TAG_W = 4,
  parameter int SET_W = 2,
  parameter int OFF_W = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           st_valid,
  input  logic [TAG_W+SET_W+OFF_W-1:0]   st_addr,
  input  logic [DW-1:0]                  st_data,
  input  logic [DW/8-1:0]                st_be,
  output logic                           st_ready,
  input  logic                           ld_valid,
  input  logic [TAG_W+SET_W+OFF_W-1:0]   ld_addr,
  output logic                           ld_hit,
  output logic [DW-1:0]                  ld_data,
  input  logic                           fill_valid,
  input  logic                           fill_way,
  input  logic [TAG_W+SET_W-1:0]         fill_line,
  input  logic [DW*(1<<OFF_W)-1:0]       fill_data
);
  localparam int NB   = DW / 8;
  localparam int SETS = 1 << SET_W;
  localparam int WPL  = 1 << OFF_W;

  logic [1:0][SETS-1:0]                  vld;
  logic [1:0][SETS-1:0][TAG_W-1:0]       tag;
  logic [1:0][SETS-1:0][WPL-1:0][DW-1:0] dat;

  logic             p_v, p_way;
  logic [SET_W-1:0] p_set;
  logic [OFF_W-1:0] p_off;
  logic [DW-1:0]    p_data;
  logic [NB-1:0]    p_be;

  logic [SET_W-1:0] st_set, ld_set, f_set;
  logic [TAG_W-1:0] st_tag, ld_tag, f_tag;
  logic [OFF_W-1:0] st_off, ld_off;
  logic [1:0]       st_hw, ld_hw;
  logic             ld_way, accept, byp;
  logic [DW-1:0]    raw, merged;

  assign st_off = st_addr[OFF_W-1:0];
  assign st_set = st_addr[OFF_W +: SET_W];
  assign st_tag = st_addr[OFF_W+SET_W +: TAG_W];
  assign ld_off = ld_addr[OFF_W-1:0];
  assign ld_set = ld_addr[OFF_W +: SET_W];
  assign ld_tag = ld_addr[OFF_W+SET_W +: TAG_W];
  assign f_set  = fill_line[SET_W-1:0];
  assign f_tag  = fill_line[SET_W +: TAG_W];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign st_hw[w] = vld[w][st_set] && (tag[w][st_set] == st_tag);
    assign ld_hw[w] = vld[w][ld_set] && (tag[w][ld_set] == ld_tag);
  end

  assign st_ready = |st_hw;
  assign accept   = st_valid && st_ready;
  assign ld_hit   = ld_valid && (|ld_hw);
  assign ld_way   = ld_hw[1];
  assign raw      = dat[ld_way][ld_set][ld_off];
  assign byp      = p_v && (p_way == ld_way) && (p_set == ld_set) && (p_off == ld_off);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign merged[b*8 +: 8] = (byp && p_be[b]) ? p_data[b*8 +: 8] : raw[b*8 +: 8];
  end

  assign ld_data = ld_hit ? merged : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      tag    <= '0;
      dat    <= '0;
      p_v    <= 1'b0;
      p_way  <= 1'b0;
      p_set  <= '0;
      p_off  <= '0;
      p_data <= '0;
      p_be   <= '0;
    end else begin
      p_v <= accept;
      if (accept) begin
        p_way  <= st_hw[1];
        p_set  <= st_set;
        p_off  <= st_off;
        p_data <= st_data;
        p_be   <= st_be;
      end
      if (p_v)
        for (int b = 0; b < NB; b++)
          if (p_be[b]) dat[p_way][p_set][p_off][b*8 +: 8] <= p_data[b*8 +: 8];
      if (fill_valid) begin
        vld[fill_way][f_set] <= 1'b1;
        tag[fill_way][f_set] <= f_tag;
        for (int o = 0; o < WPL; o++)
          dat[fill_way][f_set][o] <= fill_data[o*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/store_pipe_cache_chk.sv
module store_pipe_cache_chk #(
  parameter int DW    = 32,
  parameter int TAG_W = 4,
  parameter int SET_W = 2,
  parameter int OFF_W = 2
) (
  input logic                                            clk,
  input logic                                            rst_n,
  input logic                                            st_valid,
  input logic                                            st_ready,
  input logic [TAG_W+SET_W+OFF_W-1:0]                    ld_addr,
  input logic                                            ld_hit,
  input logic [DW-1:0]                                   ld_data,
  input logic                                            fill_valid,
  input logic                                            fill_way,
  input logic [TAG_W+SET_W-1:0]                          fill_line,
  input logic                                            p_v,
  input logic                                            p_way,
  input logic [SET_W-1:0]                                p_set,
  input logic [OFF_W-1:0]                                p_off,
  input logic [DW-1:0]                                   p_data,
  input logic [DW/8-1:0]                                 p_be,
  input logic [1:0][(1<<SET_W)-1:0]                      vld,
  input logic [1:0][(1<<SET_W)-1:0][TAG_W-1:0]           tag,
  input logic [1:0][(1<<SET_W)-1:0][(1<<OFF_W)-1:0][DW-1:0] dat
);
  localparam int NB = DW / 8;
  logic [DW-1:0]    mask;
  logic             other;
  logic [SET_W-1:0] fs, ls;
  logic [TAG_W-1:0] ft, lt;
  logic [OFF_W-1:0] lo;

  for (genvar b = 0; b < NB; b++) begin : g_m
    assign mask[b*8 +: 8] = {8{p_be[b]}};
  end
  assign other = ~p_way;
  assign fs = fill_line[SET_W-1:0];
  assign ft = fill_line[SET_W +: TAG_W];
  assign lo = ld_addr[OFF_W-1:0];
  assign ls = ld_addr[OFF_W +: SET_W];
  assign lt = ld_addr[OFF_W+SET_W +: TAG_W];

  assert_stall_no_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && !st_ready |=> !p_v);

  assert_pending_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
    p_v && !(fill_valid && fill_way == p_way && fs == p_set) |=>
    ((dat[$past(p_way)][$past(p_set)][$past(p_off)] ^ $past(p_data)) & $past(mask)) == '0);

  assert_other_way_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    p_v && !fill_valid |=>
    dat[$past(other)][$past(p_set)][$past(p_off)] == $past(dat[other][p_set][p_off]));

  assert_bypass_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit && p_v && ls == p_set && lo == p_off && vld[p_way][p_set] && tag[p_way][p_set] == lt
    |-> ((ld_data ^ p_data) & mask) == '0);

  assert_fill_installs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> vld[$past(fill_way)][$past(fs)] && tag[$past(fill_way)][$past(fs)] == $past(ft));
endmodule

bind store_pipe_cache store_pipe_cache_chk #(
  .DW(DW), .TAG_W(TAG_W), .SET_W(SET_W), .OFF_W(OFF_W)
) u_chk (.*);

// File: tb/sim_store_pipe_cache.sv
`timescale 1ns/1ps
module sim_store_pipe_cache;
  logic clk = 0, rst_n = 0;
  logic st_valid = 0, st_ready, ld_valid = 0, ld_hit, fill_valid = 0, fill_way = 0;
  logic [7:0] st_addr = 0, ld_addr = 0;
  logic [31:0] st_data = 0, ld_data;
  logic [3:0] st_be = 0;
  logic [5:0] fill_line = 0;
  logic [127:0] fill_data = 0;

  int errors = 0, checks = 0;
  logic [31:0] refmem [256];
  bit cval [2][4];
  logic [3:0] ctag [2][4];

  always #5 clk = ~clk;

  store_pipe_cache u0 (.*);

  function automatic bit cached(input logic [7:0] a);
    for (int w = 0; w < 2; w++)
      if (cval[w][a[3:2]] && ctag[w][a[3:2]] == a[7:4]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input bit sv, input logic [7:0] sa, input logic [31:0] sd,
                      input logic [3:0] sb, input logic [7:0] la, input bit fv,
                      input bit fw, input logic [5:0] fl, input string req);
    bit eh;
    logic [31:0] ed;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
    ld_valid = 1; ld_addr = la;
    fill_valid = fv; fill_way = fw; fill_line = fl;
    for (int o = 0; o < 4; o++) fill_data[o*32 +: 32] = refmem[{fl, o[1:0]}];
    #1;
    eh = cached(la);
    ed = eh ? refmem[la] : 32'h0;
    checks++;
    if (ld_hit !== eh || ld_data !== ed) begin
      errors++;
      $display("FAIL %s load %h: hit=%b data=%h expected hit=%b data=%h", req, la, ld_hit, ld_data, eh, ed);
    end
    if (sv) begin
      checks++;
      if (st_ready !== cached(sa)) begin
        errors++;
        $display("FAIL %s store %h: ready=%b expected %b", req, sa, st_ready, cached(sa));
      end
      if (cached(sa))
        for (int b = 0; b < 4; b++) if (sb[b]) refmem[sa][b*8 +: 8] = sd[b*8 +: 8];
    end
    if (fv) begin
      ctag[fw][fl[1:0]] = fl[5:2];
      cval[fw][fl[1:0]] = 1'b1;
    end
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 256; a++) step(0, 8'h0, 32'h0, 4'h0, a[7:0], 0, 0, 6'h0, req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin
      logic [7:0] x;
      x = a[7:0];
      refmem[a] = {x, x ^ 8'hA5, ~x, x + 8'd7};
    end
    for (int w = 0; w < 2; w++) for (int s = 0; s < 4; s++) begin
      cval[w][s] = 0; ctag[w][s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    sweep("R1");
    step(1, 8'h00, 32'h1234_5678, 4'hF, 8'h00, 0, 0, 6'h0, "R1");

    // R9 and R2: fill both ways of every set, then look up all addresses
    for (int s = 0; s < 4; s++) begin
      step(0, 0, 0, 0, 8'h00, 1, 0, {4'd0, s[1:0]}, "R9");
      step(0, 0, 0, 0, 8'h00, 1, 1, {4'd1, s[1:0]}, "R9");
    end
    sweep("R2");

    // R4 R6 R7 R8: back-to-back stores, each reloaded in the next cycle via bypass
    for (int a = 0; a < 32; a++) begin
      logic [7:0] pa;
      pa = (a == 0) ? 8'h00 : 8'(a - 1);
      step(1, a[7:0], 32'hC0DE_0000 ^ (32'(a) * 32'h0101_0101), 4'((a % 15) + 1), pa, 0, 0, 6'h0, "R7");
    end
    step(0, 0, 0, 0, 8'h1F, 0, 0, 6'h0, "R7");
    // R5 R6: whole space after the writes drained
    sweep("R5");

    // R8: stores to one word on consecutive cycles
    step(1, 8'h05, 32'hAAAA_AAAA, 4'b0001, 8'h05, 0, 0, 6'h0, "R8");
    step(1, 8'h05, 32'hBBBB_BBBB, 4'b0010, 8'h05, 0, 0, 6'h0, "R8");
    step(1, 8'h05, 32'hCCCC_CCCC, 4'b1100, 8'h05, 0, 0, 6'h0, "R8");
    step(0, 0, 0, 0, 8'h05, 0, 0, 6'h0, "R8");
    step(0, 0, 0, 0, 8'h05, 0, 0, 6'h0, "R8");
    step(0, 0, 0, 0, 8'h15, 0, 0, 6'h0, "R5");

    // R3: store to an absent line stalls and changes nothing
    for (int i = 0; i < 4; i++)
      step(1, 8'h45, 32'hDEAD_BEEF, 4'hF, (i % 2) ? 8'h05 : 8'h45, 0, 0, 6'h0, "R3");
    // R9: fill way 0 of set 1 with tag 4 while the store is held
    step(1, 8'h45, 32'hDEAD_BEEF, 4'hF, 8'h05, 1, 0, 6'h11, "R9");
    step(1, 8'h45, 32'hDEAD_BEEF, 4'hF, 8'h45, 0, 0, 6'h0, "R9");
    step(0, 0, 0, 0, 8'h45, 0, 0, 6'h0, "R4");
    step(0, 0, 0, 0, 8'h05, 0, 0, 6'h0, "R9");
    sweep("R9");

    // R6: single-byte stores across all lanes of one word, other way unchanged
    for (int b = 0; b < 4; b++)
      step(1, 8'h1A, 32'h0101_0101 * 32'(b + 3), 4'(1 << b), 8'h1A, 0, 0, 6'h0, "R6");
    step(0, 0, 0, 0, 8'h1A, 0, 0, 6'h0, "R6");
    step(0, 0, 0, 0, 8'h0A, 0, 0, 6'h0, "R5");
    sweep("R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule